// File: doc/BRIEF.md
# Memory-Mapped Write to Packet Stream Converter

This block sits behind a network DMA engine that writes received packets into what it takes to be a memory buffer. It presents a write-only AXI4 slave split into two pages. Bursts that land in the data page are turned beat by beat into an AXI-Stream. A write that lands in the control page is a completion notice: software posts one for each packet after the DMA signals that the packet has finished.

The bus does not carry packet boundaries, so the block infers them from two hints that can arrive in any order. A data burst that starts at offset zero of the data page means a new packet has begun. A completion write means the current packet has ended. The newest data beat is always kept back in a one-entry holding stage, so TLAST can still be attached to it once a boundary is seen. A small counter records packets that a wrap has already closed, so that their late completion writes are absorbed and each packet gets TLAST exactly once.

Top module: `mm_pkt_stream_conv`

## Requirements
- R1: After reset `s_tvalid` is 0, `awready` is 1 and `bvalid` is 0. No beat is held and the closed-packet counter is zero, so a completion write issued first produces no stream beat.
- R2: Address bit PAGE_BITS selects the page: 0 is the data page and 1 is the control page. Beats to the control page never appear on the stream.
- R3: Every accepted data-page beat leaves the stream exactly once, in arrival order and with its `wdata` unchanged. The newest beat is held back until the next data beat or a completion write releases it.
- R4: When the first beat of a data-page burst has all address bits below PAGE_BITS at zero and a beat is held, the held beat is emitted with TLAST=1 and the closed-packet counter increments.
- R5: A completion write while the counter is zero and a beat is held emits that beat with TLAST=1 and leaves the stage empty.
- R6: A completion write while the counter is nonzero decrements it and emits nothing. A completion write with the counter at zero and nothing held has no effect.
- R7: However wraps and completion writes interleave, each packet produces exactly one TLAST=1 beat.
- R8: While `s_tvalid`=1 and `s_tready`=0, `s_tvalid`, `s_tdata`, `s_tkeep` and `s_tlast` hold steady. `wready` is 0 whenever accepting the beat would need to move the held beat into a full output register, so no data is lost.
- R9: Each burst, on either page, gets exactly one write response with `bresp`=2'b00 (OKAY) after its WLAST beat is accepted. No new write address is accepted until that response completes.
- R10: `s_tkeep` is all ones on beats with TLAST=0. On a TLAST=1 beat it equals the `wstrb` that beat carried when it was written.
- R11: Only the first beat of a burst is tested for offset zero. A data burst that starts at a nonzero offset never marks a boundary, even when it continues a packet across bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | PAGE_BITS+1 | Write address; top bit is the page select |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| wlast | input | 1 | Last beat of burst |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| s_tvalid | output | 1 | Stream beat valid |
| s_tready | input | 1 | Stream beat ready |
| s_tdata | output | DATA_W | Stream data |
| s_tkeep | output | DATA_W/8 | Stream byte keep |
| s_tlast | output | 1 | Packet end marker |

## Verification
Two events can share a cycle: a new data beat pushes the held beat into the output register while the stream consumer takes the previous output beat. This is provoked by running back-to-back data bursts while `s_tready` toggles on a short pattern and also while it is stuck low. It is judged by comparing the full captured beat sequence (data, keep, last) with a model built from the requirements, and by checking that `wready` falls and the output stays frozen during the stall. The wrap and completion hints are interleaved in several orders, and the bench counts TLAST beats per packet.

// File: rtl/mmps_pkg.sv
`timescale 1ns/1ps
package mmps_pkg;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef struct packed {
        logic active;    // burst address accepted, data not finished
        logic ctrl;      // burst targets the control page
        logic zero_off;  // burst started at page offset zero
        logic first;     // next beat is the first of the burst
        logic bvalid;    // response pending
    } burst_st_t;

endpackage

// File: rtl/mmps_burst_ctl.sv
`timescale 1ns/1ps
module mmps_burst_ctl
    import mmps_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               awvalid,
    output logic               awready,
    input  logic [PAGE_BITS:0] awaddr,
    input  logic               beat_fire,
    input  logic               beat_last,
    output logic               bvalid,
    input  logic               bready,
    output logic [1:0]         bresp,
    output logic               active,
    output logic               to_ctrl,
    output logic               wrap_beat
);

    burst_st_t st_d, st_q;

    assign awready   = !st_q.active && !st_q.bvalid;
    assign bvalid    = st_q.bvalid;
    assign bresp     = RESP_OKAY;
    assign active    = st_q.active;
    assign to_ctrl   = st_q.ctrl;
    assign wrap_beat = st_q.active && !st_q.ctrl && st_q.first && st_q.zero_off;

    always_comb begin
        st_d = st_q;
        if (awvalid && awready) begin
            st_d.active   = 1'b1;
            st_d.ctrl     = awaddr[PAGE_BITS];
            st_d.zero_off = (awaddr[PAGE_BITS-1:0] == '0);
            st_d.first    = 1'b1;
        end
        if (beat_fire) begin
            st_d.first = 1'b0;
            if (beat_last) begin
                st_d.active = 1'b0;
                st_d.bvalid = 1'b1;
            end
        end
        if (st_q.bvalid && bready) begin
            st_d.bvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a finished burst always raises a response next cycle
    p_resp_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && beat_last) |=> bvalid);

    // R9: an accepted address closes the address channel until the response
    p_single_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready) |=> !awready);

endmodule

// File: rtl/mmps_beat_stage.sv
`timescale 1ns/1ps
module mmps_beat_stage #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                to_ctrl,
    input  logic                wrap_beat,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic                beat_fire,
    output logic                tvalid,
    input  logic                tready,
    output logic [DATA_W-1:0]   tdata,
    output logic [DATA_W/8-1:0] tkeep,
    output logic                tlast
);

    localparam int STRB_W = DATA_W / 8;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic              hold_v;
        logic [DATA_W-1:0] hold_d;
        logic [STRB_W-1:0] hold_s;
        logic [CNT_W-1:0]  cnt;
        logic              tv;
        logic [DATA_W-1:0] td;
        logic [STRB_W-1:0] tk;
        logic              tl;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic out_free, move_held, mark_last;

    assign out_free  = !st_q.tv || tready;
    assign move_held = st_q.hold_v && (!to_ctrl || st_q.cnt == '0);
    assign mark_last = to_ctrl || wrap_beat;
    assign wready    = active && (!move_held || out_free);
    assign beat_fire = wvalid && wready;

    assign tvalid = st_q.tv;
    assign tdata  = st_q.td;
    assign tkeep  = st_q.tk;
    assign tlast  = st_q.tl;

    always_comb begin
        st_d = st_q;
        if (st_q.tv && tready) st_d.tv = 1'b0;
        if (beat_fire && move_held) begin
            st_d.tv = 1'b1;
            st_d.td = st_q.hold_d;
            st_d.tl = mark_last;
            st_d.tk = mark_last ? st_q.hold_s : '1;
        end
        if (beat_fire && !to_ctrl) begin
            st_d.hold_v = 1'b1;
            st_d.hold_d = wdata;
            st_d.hold_s = wstrb;
            if (wrap_beat && st_q.hold_v && st_q.cnt != CNT_MAX)
                st_d.cnt = st_q.cnt + CNT_ONE;
        end
        if (beat_fire && to_ctrl) begin
            if (st_q.cnt != '0)     st_d.cnt    = st_q.cnt - CNT_ONE;
            else if (st_q.hold_v)   st_d.hold_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a stalled stream beat does not change
    p_stream_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tkeep) && $stable(tlast)));

    // R8: no data beat is taken while the held beat has nowhere to go
    p_no_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold_v && tvalid && !tready && !to_ctrl) |-> !wready);

    // R5: completion with no closed packet pending terminates the held beat
    p_ctrl_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && to_ctrl && st_q.cnt == '0 && st_q.hold_v) |=> (tvalid && tlast && !st_q.hold_v));

    // R6: completion for a packet already closed by a wrap only decrements
    p_cnt_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && to_ctrl && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE));

    // R7: the closed-packet counter never saturates in legal traffic
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && wrap_beat && st_q.hold_v) |-> (st_q.cnt != CNT_MAX));

endmodule

// File: rtl/mm_pkt_stream_conv.sv
`timescale 1ns/1ps
module mm_pkt_stream_conv #(
    parameter int PAGE_BITS = 12,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awvalid,
    output logic                awready,
    input  logic [PAGE_BITS:0]  awaddr,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wlast,
    output logic                bvalid,
    input  logic                bready,
    output logic [1:0]          bresp,
    output logic                s_tvalid,
    input  logic                s_tready,
    output logic [DATA_W-1:0]   s_tdata,
    output logic [DATA_W/8-1:0] s_tkeep,
    output logic                s_tlast
);

    logic beat_fire, active, to_ctrl, wrap_beat;

    mmps_burst_ctl #(.PAGE_BITS(PAGE_BITS)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .awvalid   (awvalid),
        .awready   (awready),
        .awaddr    (awaddr),
        .beat_fire (beat_fire),
        .beat_last (wlast),
        .bvalid    (bvalid),
        .bready    (bready),
        .bresp     (bresp),
        .active    (active),
        .to_ctrl   (to_ctrl),
        .wrap_beat (wrap_beat)
    );

    mmps_beat_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .to_ctrl   (to_ctrl),
        .wrap_beat (wrap_beat),
        .wvalid    (wvalid),
        .wready    (wready),
        .wdata     (wdata),
        .wstrb     (wstrb),
        .beat_fire (beat_fire),
        .tvalid    (s_tvalid),
        .tready    (s_tready),
        .tdata     (s_tdata),
        .tkeep     (s_tkeep),
        .tlast     (s_tlast)
    );

endmodule

// File: tb/mm_pkt_stream_conv_tb.sv
`timescale 1ns/1ps
module mm_pkt_stream_conv_tb;

    localparam int PAGE_BITS = 12;
    localparam int DATA_W    = 32;
    localparam int STRB_W    = DATA_W / 8;
    localparam int CNT_W     = 4;
    localparam int ENT_W     = 1 + STRB_W + DATA_W;
    localparam logic [PAGE_BITS:0] CTRL_ADDR = (PAGE_BITS+1)'(1) << PAGE_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic awvalid = 0, awready, wvalid = 0, wready, wlast = 0;
    logic bvalid, bready = 1'b1, s_tvalid, s_tready = 1'b1, s_tlast;
    logic [PAGE_BITS:0] awaddr = '0;
    logic [DATA_W-1:0] wdata = '0, s_tdata;
    logic [STRB_W-1:0] wstrb = '0, s_tkeep;
    logic [1:0] bresp;

    mm_pkt_stream_conv #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit rdy_toggle = 0, rdy_force = 1;
    always @(posedge clk) begin
        cyc++;
        #1 s_tready = rdy_toggle ? (cyc % 3 != 0) : rdy_force;
    end

    logic [ENT_W-1:0] got_q[$], exp_q[$];
    always @(negedge clk)
        if (rst_n && s_tvalid && s_tready) got_q.push_back({s_tlast, s_tkeep, s_tdata});

    // requirement-level model of the expected stream
    bit m_hv = 0; logic [DATA_W-1:0] m_hd; logic [STRB_W-1:0] m_hs; int m_cnt = 0;

    task automatic model_data(logic [DATA_W-1:0] d, logic [STRB_W-1:0] s, bit wrap);
        if (m_hv) begin
            exp_q.push_back({wrap, wrap ? m_hs : {STRB_W{1'b1}}, m_hd});
            if (wrap) m_cnt++;
        end
        m_hv = 1; m_hd = d; m_hs = s;
    endtask

    task automatic model_ctrl();
        if (m_cnt > 0) m_cnt--;
        else if (m_hv) begin
            exp_q.push_back({1'b1, m_hs, m_hd});
            m_hv = 0;
        end
    endtask

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_burst(logic [PAGE_BITS:0] addr, int n, logic [DATA_W-1:0] base,
                               logic [STRB_W-1:0] last_strb);
        @(posedge clk); #1;
        awvalid = 1; awaddr = addr;
        forever begin @(negedge clk); if (awready) break; end
        @(posedge clk); #1;
        awvalid = 0;
        for (int i = 0; i < n; i++) begin
            wvalid = 1; wdata = base + DATA_W'(i);
            wstrb = (i == n - 1) ? last_strb : '1;
            wlast = (i == n - 1);
            forever begin @(negedge clk); if (wready) break; end
            if (addr[PAGE_BITS]) model_ctrl();
            else model_data(wdata, wstrb, i == 0 && addr[PAGE_BITS-1:0] == '0);
            @(posedge clk); #1;
        end
        wvalid = 0; wlast = 0;
        forever begin @(negedge clk); if (bvalid) break; end
        check(bresp == 2'b00, "R9", "bresp per burst", 64'(bresp), 64'd0);
        @(posedge clk); #1;
        check(!bvalid, "R9", "single response", 64'(bvalid), 64'd0);
    endtask

    task automatic complete();
        write_burst(CTRL_ADDR, 1, 32'hC0DE_0000, '1);
    endtask

    task automatic compare(string req);
        repeat (20) @(negedge clk);
        check(got_q.size() == exp_q.size(), req, "beat count",
              64'(got_q.size()), 64'(exp_q.size()));
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            check(got_q[i] == exp_q[i], req, $sformatf("beat %0d {last,keep,data}", i),
                  64'(got_q[i]), 64'(exp_q[i]));
        got_q.delete(); exp_q.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!s_tvalid, "R1", "tvalid after reset", 64'(s_tvalid), 64'd0);
        check(awready, "R1", "awready after reset", 64'(awready), 64'd1);
        check(!bvalid, "R1", "bvalid after reset", 64'(bvalid), 64'd0);
        complete();
        compare("R1 R6 R2");
    endtask

    task automatic t_single_packet();
        write_burst('0, 4, 32'h1000_0000, 4'b0011);
        complete();
        compare("R3 R5 R10 R2");
    endtask

    task automatic t_wrap_before_completion();
        write_burst('0, 3, 32'h2000_0000, 4'b0111);
        write_burst('0, 2, 32'h2100_0000, 4'b0001);
        compare("R4 R10");
        complete();
        compare("R6");
        complete();
        compare("R5 R7");
    endtask

    task automatic t_multi_burst_packet();
        write_burst('0, 3, 32'h3000_0000, '1);
        write_burst(13'h00C, 2, 32'h3100_0000, 4'b0011);
        compare("R11");
        complete();
        compare("R11 R10");
    endtask

    task automatic t_backpressure();
        logic [DATA_W-1:0] snap;
        rdy_force = 0;
        fork
            write_burst('0, 3, 32'h4000_0000, 4'b1111);
            begin
                repeat (7) @(negedge clk);
                snap = s_tdata;
                @(negedge clk);
                check(wvalid && !wready, "R8", "wready low while stalled", 64'(wready), 64'd0);
                check(s_tvalid && s_tdata == snap, "R8", "output frozen",
                      64'(s_tdata), 64'(snap));
                check(s_tdata == 32'h4000_0000, "R8", "oldest beat at output",
                      64'(s_tdata), 64'h4000_0000);
                rdy_force = 1;
            end
        join
        complete();
        compare("R8 R3");
    endtask

    task automatic t_mixed_orders();
        int lasts = 0;
        rdy_toggle = 1;
        write_burst('0, 2, 32'h5000_0000, 4'b0001);
        write_burst('0, 1, 32'h5100_0000, 4'b0011);
        complete(); complete();
        write_burst('0, 3, 32'h5200_0000, 4'b0111);
        write_burst(13'h010, 1, 32'h5280_0000, 4'b1111);
        complete();
        write_burst('0, 1, 32'h5300_0000, 4'b0001);
        write_burst('0, 2, 32'h5400_0000, 4'b0011);
        write_burst('0, 2, 32'h5500_0000, 4'b0111);
        complete(); complete(); complete();
        complete();
        repeat (20) @(negedge clk);
        foreach (got_q[i]) if (got_q[i][ENT_W-1]) lasts++;
        check(lasts == 6, "R7", "one TLAST per packet", 64'(lasts), 64'd6);
        compare("R7 R3");
        rdy_toggle = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_single_packet();
        t_wrap_before_completion();
        t_multi_burst_packet();
        t_backpressure();
        t_mixed_orders();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule